// File: doc/BRIEF.md
# Nibble-Loaded Double-Buffered DAC Register

This block is the digital input stage of a 12-bit converter that sits on a narrow processor bus as a memory-mapped output. The processor writes a 12-bit code four bits at a time. Three addresses place a nibble into one of three holding registers. A fourth address copies all three holding registers into the 12-bit output register in one step. The converter core reads the output register, so it only ever sees a complete word.

Each bus access is a plain write cycle. The host drives the address and the data, pulls the active-low select low, and pulses the active-low write strobe. The strobe, the select, the address and the data are all sampled on the system clock. The write takes effect on the low-to-high transition of the strobe. A separate active-low clear input zeroes the output register at once, with no clock edge needed. It does not touch the holding registers.

Top module: `nibble_dac_loader`

## Requirements
- R1: After system reset, `code` is 0.
- R2: The write address picks the operation:
  - address 0 loads the nibble that lands in `code[3:0]`;
  - address 1 loads the nibble that lands in `code[7:4]`;
  - address 2 loads the nibble that lands in `code[11:8]`;
  - address 3 copies all three holding nibbles into `code` as {high, middle, low}.
- R3: Writes to addresses 0 to 2 do not change `code` until a later write to address 3.
- R4: A write is triggered by the low-to-high transition of `wr_n`. It uses the address and data that were present while `wr_n` was still low. New values that appear together with the rising strobe are not used.
- R5: A strobe that completes while `cs_n` was high changes neither the holding registers nor `code`.
- R6: While `clr_n` is low, `code` is 0. It goes to 0 without waiting for a clock edge.
- R7: Clear leaves the holding registers intact. After `clr_n` is released, `code` stays 0 through nibble writes until the next transfer.
- R8: A transfer leaves the holding registers unchanged, so a repeated transfer reproduces the same code.
- R9: A transfer shows on `code` after the third rising clock edge that follows the rise of `wr_n`. After the second such edge, `code` still holds the old value.
- R10: If `clr_n` is low at the clock edge where a transfer would take effect, clear wins. The transfer is lost and `code` stays 0.
- R11: If `cs_n` and `wr_n` rise in the same clock period, the write is still treated as selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| clr_n | input | 1 | Active-low asynchronous clear of the output register |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe; acts on its rising transition |
| addr | input | 2 | Operation address (0 to 2 nibble, 3 transfer) |
| din | input | 4 | Nibble data |
| code | output | 12 | Output code for the converter core |

## Verification
Two functions can collide on the output register: the asynchronous clear and a transfer whose synchronized strobe edge falls on the same clock edge. The bench provokes this by raising the strobe of a transfer and pulling clear low before the third clock edge that follows. It then holds clear low across the edge where the load would have happened. The result is judged on two points. First, `code` must remain 0 after clear is released. Second, the holding registers must be intact, so a fresh transfer brings back the earlier word.

// File: rtl/nibble_dac_loader.sv
module nibble_dac_loader #(
  parameter int NIB_W = 4,
  parameter int NIBS  = 3,
  parameter int SYNC  = 2,
  localparam int AW   = $clog2(NIBS + 1),
  localparam int CW   = NIB_W * NIBS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [NIB_W-1:0] din,
  output logic [CW-1:0]    code
);

  logic [SYNC:0]                wr_p, cs_p;
  logic [SYNC:0][AW-1:0]        a_p;
  logic [SYNC:0][NIB_W-1:0]     d_p;
  logic [NIBS-1:0][NIB_W-1:0]   hold;
  logic [NIBS-1:0]              nib_we;
  logic                         fire, xfer;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_p <= '1;
      cs_p <= '1;
      a_p  <= '0;
      d_p  <= '0;
    end else begin
      wr_p <= {wr_p[SYNC-1:0], wr_n};
      cs_p <= {cs_p[SYNC-1:0], cs_n};
      a_p  <= {a_p[SYNC-1:0], addr};
      d_p  <= {d_p[SYNC-1:0], din};
    end

  assign fire = wr_p[SYNC-1] & ~wr_p[SYNC] & ~cs_p[SYNC];
  assign xfer = fire && (a_p[SYNC] == AW'(NIBS));

  always_comb
    for (int i = 0; i < NIBS; i++)
      nib_we[i] = fire && (a_p[SYNC] == AW'(i));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold <= '0;
    else
      for (int i = 0; i < NIBS; i++)
        if (nib_we[i]) hold[i] <= d_p[SYNC];

  always_ff @(posedge clk or negedge rst_n or negedge clr_n)
    if (!rst_n || !clr_n) code <= '0;
    else if (xfer)        code <= hold;

endmodule

// File: rtl/nibble_dac_loader_chk.sv
module nibble_dac_loader_chk #(
  parameter int NIB_W = 4,
  parameter int NIBS  = 3,
  localparam int CW   = NIB_W * NIBS
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_n,
  input logic [CW-1:0]   code,
  input logic [CW-1:0]   hold,
  input logic [NIBS-1:0] nib_we,
  input logic            xfer
);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> code == '0); // R6

  AST_CODE_WAITS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && $past(clr_n) && !$past(xfer)) |-> $stable(code)); // R3

  AST_XFER_LOADS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer) && clr_n && $past(clr_n)) |-> code == $past(hold)); // R2

  AST_XFER_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xfer) |-> hold == $past(hold)); // R8

  AST_ONE_OPERATION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nib_we, xfer})); // R2

  AST_IDLE_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|nib_we) |-> $stable(hold)); // R5

endmodule

bind nibble_dac_loader nibble_dac_loader_chk #(.NIB_W(NIB_W), .NIBS(NIBS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .code(code),
  .hold(hold), .nib_we(nib_we), .xfer(xfer)
);

// File: tb/nibble_dac_loader_test.sv
`timescale 1ns/100ps
module nibble_dac_loader_test;
  logic clk = 0, rst_n = 0, clr_n = 1, cs_n = 1, wr_n = 1;
  logic [1:0]  addr = '0;
  logic [3:0]  din  = '0;
  logic [11:0] code;

  int checks = 0, fails = 0;
  string req = "R1";
  bit done = 0;

  typedef struct { bit wr; bit cs; int a; int d; } smp_t;
  smp_t q[$];
  int m_hold[3];
  int m_code = 0;

  nibble_dac_loader uut (.clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n),
                         .wr_n(wr_n), .addr(addr), .din(din), .code(code));

  always #2.5 clk = ~clk;

  // reference model: strobe rise seen two edges back, values from one edge before it
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_hold = '{0, 0, 0};
      m_code = 0;
    end else begin
      smp_t s;
      s.wr = wr_n; s.cs = cs_n; s.a = int'(addr); s.d = int'(din);
      q.push_front(s);
      if (q.size() > 4) void'(q.pop_back());
      if (q.size() == 4 && q[2].wr && !q[3].wr && !q[3].cs) begin
        if (q[3].a == 3) begin
          if (clr_n) m_code = m_hold[2] * 256 + m_hold[1] * 16 + m_hold[0];
        end else m_hold[q[3].a] = q[3].d;
      end
      if (!clr_n) m_code = 0;
    end
  end

  always @(negedge clr_n) m_code = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string r);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: code actual %03h expected %03h at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) chk(32'(code), 32'(m_code), req);

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_code(input int exp, input string r);
    @(negedge clk);
    chk(32'(code), 32'(exp), r);
    tick(1);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [3:0] d, input bit sel = 1,
                        input bit late = 0, input bit cs_with_wr = 0);
    addr = a; din = d; cs_n = !sel;
    tick(2);
    wr_n = 0;
    tick(3);
    wr_n = 1;
    if (late) begin din = ~d; addr = a + 2'd1; end
    if (cs_with_wr) cs_n = 1;
    tick(1);
    cs_n = 1;
    tick(4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    expect_code(0, "R1");

    req = "R3";
    bus_wr(2'd0, 4'h5);
    bus_wr(2'd1, 4'hA);
    bus_wr(2'd2, 4'h3);
    expect_code(0, "R3");

    req = "R2";
    bus_wr(2'd3, 4'h0);
    expect_code('h3A5, "R2");

    req = "R9";
    bus_wr(2'd0, 4'h7);
    addr = 2'd3; cs_n = 0;
    tick(2);
    wr_n = 0;
    tick(3);
    wr_n = 1;
    tick(2);
    @(negedge clk); chk(32'(code), 32'h3A5, "R9");
    tick(1);
    @(negedge clk); chk(32'(code), 32'h3A7, "R9");
    cs_n = 1;
    tick(3);

    req = "R8";
    bus_wr(2'd3, 4'h0);
    expect_code('h3A7, "R8");

    req = "R5";
    bus_wr(2'd0, 4'hF, 0);
    bus_wr(2'd3, 4'h0, 0);
    expect_code('h3A7, "R5");
    bus_wr(2'd3, 4'h0);
    expect_code('h3A7, "R5");

    req = "R4";
    bus_wr(2'd1, 4'h2, 1, 1);
    bus_wr(2'd3, 4'h0);
    expect_code('h327, "R4");

    req = "R11";
    bus_wr(2'd2, 4'h9, 1, 0, 1);
    bus_wr(2'd3, 4'h0);
    expect_code('h927, "R11");

    req = "R6";
    clr_n = 0;
    #1 chk(32'(code), 32'h0, "R6");
    tick(2);
    clr_n = 1;
    tick(2);
    req = "R7";
    expect_code(0, "R7");
    bus_wr(2'd0, 4'h1);
    expect_code(0, "R7");
    bus_wr(2'd3, 4'h0);
    expect_code('h921, "R7");

    req = "R10";
    bus_wr(2'd1, 4'h6);
    clr_n = 0;
    tick(2);
    clr_n = 1;
    tick(1);
    addr = 2'd3; cs_n = 0;
    tick(2);
    wr_n = 0;
    tick(3);
    wr_n = 1;
    tick(1);
    clr_n = 0;
    tick(4);
    clr_n = 1; cs_n = 1;
    tick(2);
    expect_code(0, "R10");
    bus_wr(2'd3, 4'h0);
    expect_code('h961, "R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule